// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core. Software reaches them through a single access port. The port carries a register number, a select value, a write-enable and write data, and a register read returns its value on the same port. Every implemented register has a fixed merge rule. On a write, some bits take the new data, some keep their stored value and the rest are forced to zero.

The block also keeps four mode flags: user mode, exception level, error level and debug mode. A status write loads the first three from its data. A debug-register write loads the debug-mode flag. The status register does not store these three bits. A status read shows them by ORing in the live flags.

The block drives a hardware interrupt request. The request is raised or withdrawn when software changes the global interrupt enable, or when a software-interrupt bit is set in the cause register. An access that uses a select the register number does not allow is refused, and a one-cycle error pulse is given.

Top module: `sysctl_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, all four mode flags are low, and both `irq_req` and `acc_err` are low.
- R2: Register numbers are decoded as follows: 0 index, 2 and 3 low translation entries, 4 context, 5 page mask, 6 wired, 10 high translation entry, 12 status, 13 cause, 23 debug. A write to index keeps bit 31 and takes bits 3:0. A write to either low entry stores bits 29:0. A write to page mask stores bits 24:13. A write to wired stores bits 3:0.
- R3: A write to the high entry stores the data ANDed with 0xFFFFF0FF. A write to context keeps bits 31:24 and takes bits 23:4.
- R4: A status write stores the data ANDed with 0xFA78FF01. A status read ORs in the user flag at bit 4, the error flag at bit 2 and the exception flag at bit 1.
- R5: A status write loads the user, error and exception flags from data bits 4, 2 and 1. A debug write loads the debug-mode flag from data bit 30. The debug register keeps bits under 0x8C03FC1F and takes bits under 0x13300120.
- R6: A cause write keeps bits under 0xB000F87C and takes only the software-interrupt bits 9:8.
- R7: `irq_req` is set on a status write when all of these hold: status bit 0 (interrupt enable) goes from 0 to 1; the exception, error and debug flags are clear after the write; and status AND cause AND 0x0000FF00 is nonzero.
- R8: `irq_req` is cleared on a status write that changes bit 0 from 1 to 0.
- R9: `irq_req` is set on a cause write when all of these hold: a software-interrupt bit goes from 0 to 1; status bit 0 is 1; the exception, error and debug flags are clear; and status AND new cause AND 0x0000FF00 is nonzero.
- R10: A nonzero select is valid only for register numbers 16 and 28. An invalid access reads zero and its write changes nothing. It raises `acc_err` for exactly the cycle after the access. A nonzero select on 16 or 28 raises no error.
- R11: Register numbers not listed in R2 read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | Write when high, read when low |
| acc_reg | input | 5 | Register number |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read value of the addressed register (combinational) |
| acc_err | output | 1 | One-cycle pulse after an invalid access |
| user_mode | output | 1 | User-mode flag |
| exc_level | output | 1 | Exception-level flag |
| err_level | output | 1 | Error-level flag |
| dbg_mode | output | 1 | Debug-mode flag |
| irq_req | output | 1 | Hardware interrupt request |

## Verification
The bench writes all ones, or a mixed pattern, to every masked register and reads it back. A wrong mask therefore shows up as stray bits or missing bits.

The interrupt sequences cover the failure cases for each gate:
- an enable rise with the interrupt-mask field zero;
- an enable rise while the exception and error flags are set, or while debug mode is set;
- an enable rise that happens while the request is already high.

A design that ignored any gate would raise the request when it must not. A design that cleared the request on the wrong edge would drop it early or keep it too long. A cause write that sets a software bit while interrupts are enabled must raise the request, so a design that re-evaluates only on status writes would miss it.

Invalid selects are applied to a real register. This exposes a design that corrupts the stored value, that returns data instead of zero, or that flags the legal selects on registers 16 and 28.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        SR_NONE, SR_INDEX, SR_LO0, SR_LO1, SR_CTX, SR_PMASK,
        SR_WIRED, SR_HI, SR_STAT, SR_CAUSE, SR_DBG
    } sreg_e;

    localparam int NUM_SLOTS = 11;

    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_UM  = 4;
    localparam int DB_DM  = 30;

    localparam logic [DATA_W-1:0] IRQ_FIELD = 32'h0000_FF00;
    localparam logic [DATA_W-1:0] SW_FIELD  = 32'h0000_0300;

    typedef struct packed {
        logic user;
        logic exl;
        logic erl;
        logic dbg;
    } mode_t;

    function automatic logic [DATA_W-1:0] keep_mask(sreg_e r);
        case (r)
            SR_INDEX: keep_mask = 32'h8000_0000;
            SR_CTX:   keep_mask = 32'hFF00_0000;
            SR_CAUSE: keep_mask = 32'hB000_F87C;
            SR_DBG:   keep_mask = 32'h8C03_FC1F;
            default:  keep_mask = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] take_mask(sreg_e r);
        case (r)
            SR_INDEX: take_mask = 32'h0000_000F;
            SR_LO0,
            SR_LO1:   take_mask = 32'h3FFF_FFFF;
            SR_CTX:   take_mask = 32'h00FF_FFF0;
            SR_PMASK: take_mask = 32'h01FF_E000;
            SR_WIRED: take_mask = 32'h0000_000F;
            SR_HI:    take_mask = 32'hFFFF_F0FF;
            SR_STAT:  take_mask = 32'hFA78_FF01;
            SR_CAUSE: take_mask = SW_FIELD;
            SR_DBG:   take_mask = 32'h1330_0120;
            default:  take_mask = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_v,
                                               logic [DATA_W-1:0] new_v,
                                               sreg_e r);
        merge = (old_v & keep_mask(r)) | (new_v & take_mask(r));
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int SEL_W = 3
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic [SEL_W-1:0] sel,
    output sreg_e            id,
    output logic             bad
);
    localparam int SEL_OK_A = 16;
    localparam int SEL_OK_B = 28;

    always_comb begin
        bad = (sel != '0) && (int'(reg_num) != SEL_OK_A) && (int'(reg_num) != SEL_OK_B);
        case (int'(reg_num))
            0:       id = SR_INDEX;
            2:       id = SR_LO0;
            3:       id = SR_LO1;
            4:       id = SR_CTX;
            5:       id = SR_PMASK;
            6:       id = SR_WIRED;
            10:      id = SR_HI;
            12:      id = SR_STAT;
            13:      id = SR_CAUSE;
            23:      id = SR_DBG;
            default: id = SR_NONE;
        endcase
        if (bad) id = SR_NONE;
    end
endmodule

// File: rtl/sysctl_slot.sv
module sysctl_slot
    import sysctl_pkg::*;
#(
    parameter sreg_e KIND = SR_INDEX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] nxt
);
    assign nxt = merge(q, d, KIND);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= nxt;
    end
endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_wr,
    input  logic              cause_wr,
    input  logic [DATA_W-1:0] stat_old,
    input  logic [DATA_W-1:0] stat_new,
    input  logic [DATA_W-1:0] cause_old,
    input  logic [DATA_W-1:0] cause_new,
    input  mode_t             mode_nxt,
    output logic              irq_req
);
    logic gates_open;
    logic stat_raise, stat_drop, cause_raise;

    always_comb begin
        gates_open  = !mode_nxt.exl && !mode_nxt.erl && !mode_nxt.dbg;
        stat_raise  = stat_wr && stat_new[ST_IE] && !stat_old[ST_IE] && gates_open &&
                      ((stat_new & cause_old & IRQ_FIELD) != '0);
        stat_drop   = stat_wr && !stat_new[ST_IE] && stat_old[ST_IE];
        cause_raise = cause_wr && ((cause_new & ~cause_old & SW_FIELD) != '0) &&
                      stat_old[ST_IE] && gates_open &&
                      ((stat_old & cause_new & IRQ_FIELD) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)                           irq_req <= 1'b0;
        else if (stat_raise || cause_raise) irq_req <= 1'b1;
        else if (stat_drop)                irq_req <= 1'b0;
    end

    AST_IRQ_DROP_ON_IE_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_req) |-> $past(stat_wr) && !$past(stat_new[ST_IE])); // R8

    AST_IRQ_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(stat_wr || cause_wr)); // R7
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [REG_W-1:0]  acc_reg,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_err,
    output logic              user_mode,
    output logic              exc_level,
    output logic              err_level,
    output logic              dbg_mode,
    output logic              irq_req
);
    sreg_e id;
    logic  bad;
    logic  wr_any;
    mode_t mode_q, mode_nxt;

    logic [DATA_W-1:0] q_arr   [NUM_SLOTS];
    logic [DATA_W-1:0] nxt_arr [NUM_SLOTS];
    logic [NUM_SLOTS*DATA_W-1:0] q_flat;

    sysctl_decode #(.REG_W(REG_W), .SEL_W(SEL_W)) u_dec (
        .reg_num(acc_reg), .sel(acc_sel), .id(id), .bad(bad)
    );

    assign wr_any     = acc_en && acc_we && !bad;
    assign q_arr[0]   = '0;
    assign nxt_arr[0] = '0;
    assign q_flat[DATA_W-1:0] = '0;

    for (genvar i = 1; i < NUM_SLOTS; i++) begin : g_slot
        sysctl_slot #(.KIND(sreg_e'(i))) u_slot (
            .clk(clk), .rst(rst),
            .wr(wr_any && (id == sreg_e'(i))),
            .d(acc_wdata), .q(q_arr[i]), .nxt(nxt_arr[i])
        );
        assign q_flat[i*DATA_W +: DATA_W] = q_arr[i];
    end

    always_comb begin
        mode_nxt = mode_q;
        if (wr_any && id == SR_STAT) begin
            mode_nxt.user = acc_wdata[ST_UM];
            mode_nxt.erl  = acc_wdata[ST_ERL];
            mode_nxt.exl  = acc_wdata[ST_EXL];
        end
        if (wr_any && id == SR_DBG) mode_nxt.dbg = acc_wdata[DB_DM];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            acc_err <= 1'b0;
        end else begin
            mode_q  <= mode_nxt;
            acc_err <= acc_en && bad;
        end
    end

    always_comb begin
        rd_data = q_arr[id];
        if (id == SR_STAT) begin
            rd_data[ST_UM]  = rd_data[ST_UM]  | mode_q.user;
            rd_data[ST_ERL] = rd_data[ST_ERL] | mode_q.erl;
            rd_data[ST_EXL] = rd_data[ST_EXL] | mode_q.exl;
        end
    end

    assign user_mode = mode_q.user;
    assign exc_level = mode_q.exl;
    assign err_level = mode_q.erl;
    assign dbg_mode  = mode_q.dbg;

    sysctl_irq u_irq (
        .clk(clk), .rst(rst),
        .stat_wr(wr_any && id == SR_STAT),
        .cause_wr(wr_any && id == SR_CAUSE),
        .stat_old(q_arr[SR_STAT]), .stat_new(nxt_arr[SR_STAT]),
        .cause_old(q_arr[SR_CAUSE]), .cause_new(nxt_arr[SR_CAUSE]),
        .mode_nxt(mode_nxt), .irq_req(irq_req)
    );

    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(acc_en && acc_we && bad) |-> $stable(q_flat)); // R10

    AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(acc_en && bad)); // R10

    AST_STATUS_LOADS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_any && id == SR_STAT) |->
            (user_mode == $past(acc_wdata[ST_UM])) && (exc_level == $past(acc_wdata[ST_EXL]))); // R5

    AST_IRQ_RISE_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> !exc_level && !err_level && !dbg_mode); // R7
endmodule

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_we = 1'b0;
    logic [4:0]  acc_reg = '0;
    logic [2:0]  acc_sel = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic        acc_err, user_mode, exc_level, err_level, dbg_mode, irq_req;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sysctl_regfile dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_reg(acc_reg), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .acc_err(acc_err), .user_mode(user_mode),
        .exc_level(exc_level), .err_level(err_level), .dbg_mode(dbg_mode),
        .irq_req(irq_req)
    );

    typedef struct packed {
        logic [4:0]  r;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  32'hFFFF_FFFF, 32'h0000_000F},  // R2 index
        '{5'd2,  32'hFFFF_FFFF, 32'h3FFF_FFFF},  // R2 low entry 0
        '{5'd3,  32'hA5A5_A5A5, 32'h25A5_A5A5},  // R2 low entry 1
        '{5'd4,  32'hFFFF_FFFF, 32'h00FF_FFF0},  // R3 context
        '{5'd5,  32'hFFFF_FFFF, 32'h01FF_E000},  // R2 page mask
        '{5'd6,  32'hFFFF_FFFF, 32'h0000_000F},  // R2 wired
        '{5'd10, 32'hFFFF_FFFF, 32'hFFFF_F0FF},  // R3 high entry
        '{5'd13, 32'hFFFF_FFFF, 32'h0000_0300},  // R6 cause
        '{5'd12, 32'h0000_FF00, 32'h0000_FF00}   // R4 status
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] r, logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_reg = r; acc_sel = s; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] r, logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_reg = r; acc_sel = s;
        #1 v = rd_data;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P*100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(5'd12, 3'd0, v); chk("R1 status", v, 32'h0);
        rd(5'd2, 3'd0, v);  chk("R1 low entry", v, 32'h0);
        chk("R1 flags/irq/err", {28'h0, user_mode, exc_level, err_level, dbg_mode} |
            {30'h0, irq_req, acc_err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].r, 3'd0, VECS[i].wd);
            rd(VECS[i].r, 3'd0, v);
            chk($sformatf("R2/R3/R4/R6 vector %0d", i), v, VECS[i].exp);
        end
        chk("R7 no irq after plain writes", {31'h0, irq_req}, 32'h0);

        // R7 enable rise with mask field zero
        wr(5'd12, 3'd0, 32'h0000_0001);
        chk("R7 masked rise", {31'h0, irq_req}, 32'h0);
        wr(5'd12, 3'd0, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_FF01);
        chk("R7 raise", {31'h0, irq_req}, 32'h1);
        // R4 R5 user flag
        wr(5'd12, 3'd0, 32'h0000_FF11);
        rd(5'd12, 3'd0, v); chk("R4 status with user", v, 32'h0000_FF11);
        chk("R5 user flag", {31'h0, user_mode}, 32'h1);
        chk("R7 irq held", {31'h0, irq_req}, 32'h1);
        // R8 enable fall
        wr(5'd12, 3'd0, 32'h0000_FF10);
        chk("R8 drop", {31'h0, irq_req}, 32'h0);
        // R7 gated by exception/error level
        wr(5'd12, 3'd0, 32'h0000_FF07);
        chk("R7 gated by exl/erl", {31'h0, irq_req}, 32'h0);
        chk("R5 exl erl", {30'h0, exc_level, err_level}, 32'h3);
        rd(5'd12, 3'd0, v); chk("R4 status with exl erl", v, 32'h0000_FF07);
        wr(5'd12, 3'd0, 32'h0000_FF00);
        chk("R5 flags cleared", {29'h0, user_mode, exc_level, err_level}, 32'h0);

        // R5 debug register and flag
        wr(5'd23, 3'd0, 32'hFFFF_FFFF);
        rd(5'd23, 3'd0, v); chk("R5 debug mask", v, 32'h1330_0120);
        chk("R5 debug flag", {31'h0, dbg_mode}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_FF01);
        chk("R7 gated by debug", {31'h0, irq_req}, 32'h0);
        wr(5'd23, 3'd0, 32'h0);
        chk("R5 debug flag clear", {31'h0, dbg_mode}, 32'h0);
        rd(5'd23, 3'd0, v); chk("R5 debug keep", v, 32'h0);

        // R9 software bit set on cause
        wr(5'd12, 3'd0, 32'h0);
        wr(5'd13, 3'd0, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_FF01);
        chk("R7 no pending", {31'h0, irq_req}, 32'h0);
        wr(5'd13, 3'd0, 32'h0000_0100);
        chk("R9 cause raise", {31'h0, irq_req}, 32'h1);
        rd(5'd13, 3'd0, v); chk("R6 cause sw bit", v, 32'h0000_0100);

        // R10 invalid access
        wr(5'd2, 3'd1, 32'h0);
        chk("R10 err after bad write", {31'h0, acc_err}, 32'h1);
        @(negedge clk);
        chk("R10 err one cycle", {31'h0, acc_err}, 32'h0);
        rd(5'd2, 3'd0, v); chk("R10 bad write ignored", v, 32'h3FFF_FFFF);
        rd(5'd2, 3'd1, v); chk("R10 bad read zero", v, 32'h0);
        chk("R10 err after bad read", {31'h0, acc_err}, 32'h1);
        wr(5'd16, 3'd1, 32'h1234_5678);
        chk("R10 legal select 16", {31'h0, acc_err}, 32'h0);
        rd(5'd28, 3'd2, v);
        chk("R10 legal select 28", {31'h0, acc_err}, 32'h0);

        // R11 unimplemented register
        wr(5'd7, 3'd0, 32'hFFFF_FFFF);
        rd(5'd7, 3'd0, v); chk("R11 unimplemented reads zero", v, 32'h0);

        finish_run();
    end
endmodule